// File: doc/BRIEF.md
# Trap Delegation Router

This block decides which privilege level's handler takes each trap. It holds one delegation mask for exceptions and one for interrupts on behalf of machine mode. When the build includes supervisor mode, it holds a second pair of masks owned by supervisor mode. Every mask is indexed by cause code. Software writes the masks through four write strobes that share one data bus. The current value of each mask can be read at an output port.

When a trap strobe arrives with its cause code, its interrupt flag and the privilege the hart was running at, the block returns the target level in the same cycle. A compile-time parameter selects the variant. In a machine-plus-user build, a machine mask bit hands a user-mode trap straight to the user handler. In a three-level build, a machine mask bit hands the trap to supervisor. A supervisor mask bit can then pass a user-mode trap on to user level. Supervisor bits can only exist underneath bits that machine mode has delegated.

Top module: `trap_route_unit`

## Requirements
- R1: After a synchronous reset, all four masks read zero and every trap is routed to machine level (2'b11).
- R2: In a build without supervisor mode, a trap raised at user privilege (2'b00) goes to user level (2'b00) when the machine mask bit for its cause is set. Every other trap goes to machine level.
- R3: In a three-level build, a trap whose machine mask bit is clear goes to machine level. A trap raised at supervisor (2'b01) or user privilege whose machine bit is set goes to supervisor level (2'b01), unless R4 applies.
- R4: In a three-level build, a user-privilege trap whose machine and supervisor mask bits are both set goes to user level.
- R5: A supervisor mask write stores only the bits whose machine mask bit is set at that moment. All other supervisor bits read zero. This holds even when the machine mask is written in the same cycle.
- R6: When a machine mask write clears a bit, the matching supervisor bit becomes zero. Setting the machine bit again later does not restore it.
- R7: A trap raised at machine privilege (2'b11, or the reserved code 2'b10) always goes to machine level. A trap raised at supervisor privilege never goes to user level.
- R8: A cause code equal to or above the mask width is never delegated and goes to machine level.
- R9: Exceptions (interrupt flag 0) consult only the exception masks, and interrupts (flag 1) consult only the interrupt masks.
- R10: The target-valid output equals the trap strobe in the same cycle. The target level reads machine while no trap is present. A mask write affects only traps in later cycles.
- R11: In a build without supervisor mode, the supervisor masks always read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_priv | input | 2 | Privilege the trap was raised at (00 user, 01 supervisor, 11 machine) |
| trap_valid | input | 1 | Trap strobe |
| trap_is_irq | input | 1 | 1 for interrupt, 0 for exception |
| trap_cause | input | CAUSE_W | Cause code |
| m_exc_we | input | 1 | Write machine exception mask |
| m_irq_we | input | 1 | Write machine interrupt mask |
| s_exc_we | input | 1 | Write supervisor exception mask |
| s_irq_we | input | 1 | Write supervisor interrupt mask |
| csr_wdata | input | XLEN | Shared write data |
| m_exc_mask | output | XLEN | Machine exception mask |
| m_irq_mask | output | XLEN | Machine interrupt mask |
| s_exc_mask | output | XLEN | Supervisor exception mask |
| s_irq_mask | output | XLEN | Supervisor interrupt mask |
| target_valid | output | 1 | Routing result valid |
| target_level | output | 2 | Handler level: 11 machine, 01 supervisor, 00 user |

## Verification
A mask write can land in the same cycle as a trap that reads the bit being written. It can also land in the same cycle as a write to the other level's mask. The bench forces both cases: it raises a user trap while setting a machine bit, and it writes machine and supervisor masks together. A behavioural model judges them. The model routes the trap with the masks as they stood before the edge, and it masks the supervisor write with the machine value from before the edge. Both builds run on one shared stimulus and are compared every clock.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;
  typedef enum logic [1:0] {
    LVL_USER  = 2'b00,
    LVL_SUPV  = 2'b01,
    LVL_RSVD  = 2'b10,
    LVL_MACH  = 2'b11
  } level_e;
endpackage

// File: rtl/deleg_mask_reg.sv
module deleg_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] write_allow,
  input  logic [W-1:0] keep_allow,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  always_comb begin
    q_next = (we ? (wdata & write_allow) : q) & keep_allow;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (q == '0));
  assert_hold_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!we && ((q & keep_allow) == q)) |=> $stable(q));
endmodule

// File: rtl/deleg_route.sv
module deleg_route
  import trap_route_pkg::*;
#(
  parameter int  XLEN    = 32,
  parameter int  CAUSE_W = 6,
  parameter bit  HAS_S   = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         priv,
  input  logic               valid,
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    m_exc,
  input  logic [XLEN-1:0]    m_irq,
  input  logic [XLEN-1:0]    s_exc,
  input  logic [XLEN-1:0]    s_irq,
  output logic [1:0]         level
);
  localparam int IDXW = $clog2(XLEN);

  logic [CAUSE_W:0] cause_ext;
  logic             in_range;
  logic [IDXW-1:0]  idx;
  logic             m_bit, s_bit, from_user, from_supv;

  always_comb begin
    cause_ext = {1'b0, cause};
    in_range  = cause_ext < (CAUSE_W+1)'(XLEN);
    idx       = cause[IDXW-1:0];
    m_bit     = in_range & (is_irq ? m_irq[idx] : m_exc[idx]);
    s_bit     = in_range & (is_irq ? s_irq[idx] : s_exc[idx]);
    from_user = (priv == LVL_USER);
    from_supv = (priv == LVL_SUPV);
    level     = LVL_MACH;
    if (valid && m_bit) begin
      if (HAS_S) begin
        if (from_user && s_bit)          level = LVL_USER;
        else if (from_user || from_supv) level = LVL_SUPV;
      end else if (from_user) begin
        level = LVL_USER;
      end
    end
  end

  assert_mach_priv_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && priv[1]) |-> (level == LVL_MACH));
  assert_supv_never_user_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && from_supv) |-> (level != LVL_USER));
  assert_wide_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (valid && !in_range) |-> (level == LVL_MACH));
  assert_user_only_from_user_R4: assert property (@(posedge clk) disable iff (rst)
    (level == LVL_USER) |-> (valid && from_user));
endmodule

// File: rtl/trap_route_unit.sv
module trap_route_unit
  import trap_route_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6,
  parameter bit HAS_S   = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cur_priv,
  input  logic               trap_valid,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               m_exc_we,
  input  logic               m_irq_we,
  input  logic               s_exc_we,
  input  logic               s_irq_we,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    m_exc_mask,
  output logic [XLEN-1:0]    m_irq_mask,
  output logic [XLEN-1:0]    s_exc_mask,
  output logic [XLEN-1:0]    s_irq_mask,
  output logic               target_valid,
  output logic [1:0]         target_level
);
  localparam logic [XLEN-1:0] ALL_ONES = '1;

  logic [XLEN-1:0] m_exc_nx, m_irq_nx, s_exc_nx, s_irq_nx;
  logic [XLEN-1:0] s_exc_keep, s_irq_keep;

  assign s_exc_keep = HAS_S ? m_exc_nx : '0;
  assign s_irq_keep = HAS_S ? m_irq_nx : '0;

  deleg_mask_reg #(.W(XLEN)) u_m_exc (
    .clk(clk), .rst(rst), .we(m_exc_we), .wdata(csr_wdata),
    .write_allow(ALL_ONES), .keep_allow(ALL_ONES),
    .q(m_exc_mask), .q_next(m_exc_nx));

  deleg_mask_reg #(.W(XLEN)) u_m_irq (
    .clk(clk), .rst(rst), .we(m_irq_we), .wdata(csr_wdata),
    .write_allow(ALL_ONES), .keep_allow(ALL_ONES),
    .q(m_irq_mask), .q_next(m_irq_nx));

  deleg_mask_reg #(.W(XLEN)) u_s_exc (
    .clk(clk), .rst(rst), .we(s_exc_we), .wdata(csr_wdata),
    .write_allow(m_exc_mask), .keep_allow(s_exc_keep),
    .q(s_exc_mask), .q_next(s_exc_nx));

  deleg_mask_reg #(.W(XLEN)) u_s_irq (
    .clk(clk), .rst(rst), .we(s_irq_we), .wdata(csr_wdata),
    .write_allow(m_irq_mask), .keep_allow(s_irq_keep),
    .q(s_irq_mask), .q_next(s_irq_nx));

  deleg_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_S(HAS_S)) u_route (
    .clk(clk), .rst(rst), .priv(cur_priv), .valid(trap_valid),
    .is_irq(trap_is_irq), .cause(trap_cause),
    .m_exc(m_exc_mask), .m_irq(m_irq_mask),
    .s_exc(s_exc_mask), .s_irq(s_irq_mask),
    .level(target_level));

  assign target_valid = trap_valid;

  assert_s_under_m_R5: assert property (@(posedge clk) disable iff (rst)
    ((s_exc_mask & ~m_exc_mask) == '0) && ((s_irq_mask & ~m_irq_mask) == '0));
  assert_m_clear_drops_s_R6: assert property (@(posedge clk) disable iff (rst)
    m_exc_we |=> ((s_exc_mask & ~$past(csr_wdata)) == '0));
  assert_idle_machine_R10: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |-> (target_level == LVL_MACH));

  generate
    if (!HAS_S) begin : g_mu_only
      assert_no_s_bits_R11: assert property (@(posedge clk) disable iff (rst)
        (s_exc_mask == '0) && (s_irq_mask == '0));
    end
  endgenerate
endmodule

// File: tb/tb_trap_route_unit.sv
module tb_trap_route_unit;
  localparam int XLEN = 32;
  localparam int CW   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] priv = 2'b00;
  logic tv = 1'b0, irq = 1'b0;
  logic [CW-1:0] cause = '0;
  logic mew = 0, miw = 0, sew = 0, siw = 0;
  logic [XLEN-1:0] wd = '0;

  logic [XLEN-1:0] a_me, a_mi, a_se, a_si, b_me, b_mi, b_se, b_si;
  logic a_v, b_v;
  logic [1:0] a_l, b_l;

  always #5 clk = ~clk;

  trap_route_unit #(.XLEN(XLEN), .CAUSE_W(CW), .HAS_S(1'b1)) dut (
    .clk(clk), .rst(rst), .cur_priv(priv), .trap_valid(tv), .trap_is_irq(irq),
    .trap_cause(cause), .m_exc_we(mew), .m_irq_we(miw), .s_exc_we(sew),
    .s_irq_we(siw), .csr_wdata(wd), .m_exc_mask(a_me), .m_irq_mask(a_mi),
    .s_exc_mask(a_se), .s_irq_mask(a_si), .target_valid(a_v), .target_level(a_l));

  trap_route_unit #(.XLEN(XLEN), .CAUSE_W(CW), .HAS_S(1'b0)) dut_mu (
    .clk(clk), .rst(rst), .cur_priv(priv), .trap_valid(tv), .trap_is_irq(irq),
    .trap_cause(cause), .m_exc_we(mew), .m_irq_we(miw), .s_exc_we(sew),
    .s_irq_we(siw), .csr_wdata(wd), .m_exc_mask(b_me), .m_irq_mask(b_mi),
    .s_exc_mask(b_se), .s_irq_mask(b_si), .target_valid(b_v), .target_level(b_l));

  // behavioural reference state: [0] three-level build, [1] machine-user build
  logic [XLEN-1:0] r_me [2], r_mi [2], r_se [2], r_si [2];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [1:0] ref_level(int b);
    int c;
    logic mb, sb;
    c = int'(cause);
    if (!tv) return 2'b11;
    if (c >= XLEN) return 2'b11;
    if (priv[1]) return 2'b11;
    mb = irq ? r_mi[b][c] : r_me[b][c];
    sb = irq ? r_si[b][c] : r_se[b][c];
    if (!mb) return 2'b11;
    if (b == 1) return (priv == 2'b00) ? 2'b00 : 2'b11;
    if (priv == 2'b00 && sb) return 2'b00;
    return 2'b01;
  endfunction

  task automatic chk(string tag, string what, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    string t3, t2;
    t3 = (tag == "") ? "R3" : tag;
    t2 = (tag == "") ? "R2" : tag;
    chk(tag == "" ? "R10" : tag, "valid", {31'b0, a_v}, {31'b0, tv});
    chk(t3, "level3", {30'b0, a_l}, {30'b0, ref_level(0)});
    chk(t2, "level2", {30'b0, b_l}, {30'b0, ref_level(1)});
    chk(tag == "" ? "R9" : tag, "m_exc", a_me, r_me[0]);
    chk(tag == "" ? "R9" : tag, "m_irq", a_mi, r_mi[0]);
    chk(tag == "" ? "R5" : tag, "s_exc", a_se, r_se[0]);
    chk(tag == "" ? "R5" : tag, "s_irq", a_si, r_si[0]);
    chk(tag == "" ? "R11" : tag, "mu_s_exc", b_se, '0);
    chk(tag == "" ? "R11" : tag, "mu_s_irq", b_si, '0);
    chk(tag == "" ? "R2" : tag, "mu_m_exc", b_me, r_me[1]);
  endtask

  task automatic model_edge();
    for (int b = 0; b < 2; b++) begin
      logic [XLEN-1:0] nme, nmi, nse, nsi;
      if (rst) begin
        r_me[b] = '0; r_mi[b] = '0; r_se[b] = '0; r_si[b] = '0;
      end else begin
        nme = mew ? wd : r_me[b];
        nmi = miw ? wd : r_mi[b];
        nse = (sew ? (wd & r_me[b]) : r_se[b]) & nme;
        nsi = (siw ? (wd & r_mi[b]) : r_si[b]) & nmi;
        if (b == 1) begin nse = '0; nsi = '0; end
        r_me[b] = nme; r_mi[b] = nmi; r_se[b] = nse; r_si[b] = nsi;
      end
    end
  endtask

  // one cycle: inputs already driven after a falling edge; check, then step
  task automatic cyc(string tag);
    #2;
    compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic drive(logic [1:0] p, logic v, logic i, int c,
                       logic me, logic mi, logic se, logic si, logic [XLEN-1:0] d);
    priv = p; tv = v; irq = i; cause = CW'(c);
    mew = me; miw = mi; sew = se; siw = si; wd = d;
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin
      r_me[b] = 'x; r_mi[b] = 'x; r_se[b] = 'x; r_si[b] = 'x;
    end
    @(negedge clk);
    rst = 1;
    @(posedge clk); model_edge(); @(negedge clk);
    @(posedge clk); model_edge(); @(negedge clk);
    rst = 0;
    // R1: reset state, user trap goes to machine
    drive(2'b00, 1, 0, 2, 0, 0, 0, 0, '0);            cyc("R1");
    // R10: trap concurrent with a machine write uses the old mask
    drive(2'b00, 1, 0, 2, 1, 0, 0, 0, 32'h0000_0104); cyc("R10");
    // R2/R3: machine bit set, user trap
    drive(2'b00, 1, 0, 2, 0, 0, 0, 0, '0);            cyc("R3");
    // R5: supervisor write masked by machine bits
    drive(2'b00, 0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF); cyc("R5");
    drive(2'b00, 0, 0, 0, 0, 0, 0, 0, '0);            cyc("R5");
    // R4: both bits set, user trap to user
    drive(2'b00, 1, 0, 8, 0, 0, 0, 0, '0);            cyc("R4");
    // R7: supervisor and machine privilege
    drive(2'b01, 1, 0, 8, 0, 0, 0, 0, '0);            cyc("R7");
    drive(2'b11, 1, 0, 8, 0, 0, 0, 0, '0);            cyc("R7");
    drive(2'b10, 1, 0, 8, 0, 0, 0, 0, '0);            cyc("R7");
    // R9: same cause as interrupt uses the (empty) interrupt masks
    drive(2'b00, 1, 1, 8, 0, 0, 0, 0, '0);            cyc("R9");
    // R8: out-of-range cause
    drive(2'b00, 1, 0, 40, 0, 0, 0, 0, '0);           cyc("R8");
    // R6: clear machine bit 8, then set it again
    drive(2'b00, 0, 0, 0, 1, 0, 0, 0, 32'h0000_0004); cyc("R6");
    drive(2'b00, 1, 0, 8, 1, 0, 0, 0, 32'h0000_0104); cyc("R6");
    drive(2'b00, 1, 0, 8, 0, 0, 0, 0, '0);            cyc("R6");
    // R5: machine and supervisor written together
    drive(2'b00, 0, 0, 0, 0, 1, 1, 1, 32'h0000_0030); cyc("R5");
    drive(2'b00, 1, 1, 4, 0, 0, 0, 1, 32'h0000_0030); cyc("R5");
    drive(2'b00, 1, 1, 4, 0, 0, 0, 0, '0);            cyc("R4");
    // R11: machine-user build ignores supervisor writes
    drive(2'b00, 0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF); cyc("R11");
    drive(2'b00, 0, 0, 0, 0, 0, 0, 0, '0);            cyc("R11");
    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      drive(2'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 40),
            ($urandom % 6) == 0, ($urandom % 6) == 0,
            ($urandom % 4) == 0, ($urandom % 4) == 0, $urandom);
      cyc("");
    end
    // R1: mid-run reset clears everything
    rst = 1;
    drive(2'b00, 0, 0, 0, 0, 0, 0, 0, '0);
    @(posedge clk); model_edge(); @(negedge clk);
    rst = 0;
    drive(2'b00, 1, 0, 2, 0, 0, 0, 0, '0);            cyc("R1");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule